// File: doc/BRIEF.md
# Register Rename and Recovery Unit

This block maps the destination registers of incoming instructions onto a larger pool of physical registers. It holds two alias tables, one speculative and one committed, plus a free pool kept as one bit per physical register. A group of up to four instructions is renamed in a single cycle. Each slot returns the physical tags of its two sources, the freshly allocated destination tag and the tag that the destination name pointed to before. That last tag is stored by the caller with the instruction in its reorder queue.

When instructions retire in program order, the caller hands back the architectural name, the new tag and the previous tag of each one. The committed table takes the new tag, and the previous tag returns to the pool. A flush pulse marks an exception taken at retirement. In one step it copies the committed table into the speculative table and returns to the pool every register that the committed state does not hold.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both tables, and physical registers NA..NP-1 (32..63 by default) form the free pool.
- R2: Each accepted slot with ren_vld and ren_wr set receives a distinct free physical register. Slots are served in index order (slot 0 first) with the lowest-numbered free registers. The speculative table then points the destination name at that register.
- R3: tag_prev of a writing slot is the mapping its destination name had before this slot was renamed. tag_dst and tag_prev read 0 for a slot that does not write.
- R4: A source or destination name that matches the destination of an earlier writing slot in the same group takes that slot's new tag. When several earlier slots match, the nearest one wins.
- R5: A retiring slot (cmt_vld) makes cmt_new the committed mapping of cmt_arch and returns cmt_old to the free pool, so it can be allocated from the next cycle on.
- R6: stall rises when the group needs more registers than the pool holds. The group is then rejected whole: no register leaves the pool and no mapping changes.
- R7: The free pool never holds more than NP-NA registers, so at most NP-NA renames are in flight at once. With that many outstanding, any further writing slot stalls.
- R8: The cycle after a flush, the speculative table equals the committed table, and exactly NP-NA registers are free: all those the committed table does not reference.
- R9: A flush overrides rename and retirement requested in the same cycle. stall is high during the flush, and neither the group nor the retiring slots have any effect.
- R10: A slot with ren_vld low, or with ren_wr low, allocates nothing and changes no mapping. It is not used as a bypass source for later slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_vld | input | W | Slot holds an instruction |
| ren_wr | input | W | Slot writes a destination register |
| ren_dst | input | W*AW | Destination architectural names, slot i at [i*AW +: AW] |
| ren_srca | input | W*AW | First source names |
| ren_srcb | input | W*AW | Second source names |
| cmt_vld | input | W | Retiring slot valid, slot 0 oldest |
| cmt_arch | input | W*AW | Architectural name of each retiring slot |
| cmt_new | input | W*PW | Tag allocated to the retiring instruction |
| cmt_old | input | W*PW | Tag that mapping replaced, to be freed |
| flush | input | 1 | Exception at retirement: restore and reclaim |
| tag_srca | output | W*PW | Physical tag of first source, slot i at [i*PW +: PW] |
| tag_srcb | output | W*PW | Physical tag of second source |
| tag_dst | output | W*PW | Newly allocated destination tag |
| tag_prev | output | W*PW | Previous mapping of the destination |
| stall | output | 1 | Group not accepted this cycle |

## Verification
The bench builds the unit with its defaults: 32 architectural names, 64 physical registers and a group of four. With only 32 spare registers, the pool can be drained in eight full groups. This makes exhaustion, the all-or-nothing refusal of a group that is two registers short, and the exact post-flush count all reachable within a few dozen cycles. A width of four allows bypass chains three slots deep. It also allows groups where an invalid slot sits between a writer and a reader, so a false bypass would be visible.

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NA = 32,
  parameter int NP = 64,
  parameter int W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    ren_vld,
  input  logic [W-1:0]    ren_wr,
  input  logic [W*$clog2(NA)-1:0] ren_dst,
  input  logic [W*$clog2(NA)-1:0] ren_srca,
  input  logic [W*$clog2(NA)-1:0] ren_srcb,
  input  logic [W-1:0]    cmt_vld,
  input  logic [W*$clog2(NA)-1:0] cmt_arch,
  input  logic [W*$clog2(NP)-1:0] cmt_new,
  input  logic [W*$clog2(NP)-1:0] cmt_old,
  input  logic            flush,
  output logic [W*$clog2(NP)-1:0] tag_srca,
  output logic [W*$clog2(NP)-1:0] tag_srcb,
  output logic [W*$clog2(NP)-1:0] tag_dst,
  output logic [W*$clog2(NP)-1:0] tag_prev,
  output logic            stall
);
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);
  localparam logic [NP-1:0] FREE_INIT = {{(NP-NA){1'b1}}, {NA{1'b0}}};

  logic [NA-1:0][PW-1:0] spec_map, comm_map;
  logic [NP-1:0] free_q, pool, taken, released, held;
  logic [W-1:0][PW-1:0] grant;
  logic [W-1:0] wr;
  logic got, shortage;

  assign wr       = ren_vld & ren_wr;
  assign shortage = $countones(wr) > $countones(free_q);
  assign stall    = flush | shortage;

  always_comb begin
    pool  = free_q;
    taken = '0;
    grant = '0;
    got   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (wr[i]) begin
        got = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (!got && pool[p]) begin
            grant[i] = PW'(p);
            pool[p]  = 1'b0;
            taken[p] = 1'b1;
            got      = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    logic [AW-1:0] na, nb, nd;
    logic [PW-1:0] ta, tb, td;
    tag_srca = '0;
    tag_srcb = '0;
    tag_dst  = '0;
    tag_prev = '0;
    for (int i = 0; i < W; i++) begin
      na = ren_srca[i*AW +: AW];
      nb = ren_srcb[i*AW +: AW];
      nd = ren_dst[i*AW +: AW];
      ta = spec_map[na];
      tb = spec_map[nb];
      td = spec_map[nd];
      for (int j = 0; j < i; j++) begin
        if (wr[j] && ren_dst[j*AW +: AW] == na) ta = grant[j];
        if (wr[j] && ren_dst[j*AW +: AW] == nb) tb = grant[j];
        if (wr[j] && ren_dst[j*AW +: AW] == nd) td = grant[j];
      end
      tag_srca[i*PW +: PW] = ta;
      tag_srcb[i*PW +: PW] = tb;
      tag_dst[i*PW +: PW]  = wr[i] ? grant[i] : '0;
      tag_prev[i*PW +: PW] = wr[i] ? td : '0;
    end
  end

  always_comb begin
    released = '0;
    for (int i = 0; i < W; i++)
      if (cmt_vld[i]) released[cmt_old[i*PW +: PW]] = 1'b1;
  end

  always_comb begin
    held = '0;
    for (int a = 0; a < NA; a++) held[comm_map[a]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NA; a++) begin
        spec_map[a] <= PW'(a);
        comm_map[a] <= PW'(a);
      end
      free_q <= FREE_INIT;
    end else if (flush) begin
      spec_map <= comm_map;
      free_q   <= ~held;
    end else begin
      if (!shortage)
        for (int i = 0; i < W; i++)
          if (wr[i]) spec_map[ren_dst[i*AW +: AW]] <= grant[i];
      free_q <= (free_q & ~(shortage ? '0 : taken)) | released;
      for (int i = 0; i < W; i++)
        if (cmt_vld[i]) comm_map[cmt_arch[i*AW +: AW]] <= cmt_new[i*PW +: PW];
    end
  end

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_q) <= NP - NA); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush && cmt_vld == '0) |=> (free_q == $past(free_q) && spec_map == $past(spec_map))); // R6
  AST_COMMIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld[0] && !flush) |=> free_q[$past(cmt_old[PW-1:0])]); // R5
  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_map == $past(comm_map))); // R8
  AST_FLUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(free_q) == NP - NA)); // R8
endmodule

// File: tb/rename_unit_tb_top.sv
`timescale 1ns/100ps
module rename_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ren_vld, ren_wr, cmt_vld;
  logic [19:0] ren_dst, ren_srca, ren_srcb, cmt_arch;
  logic [23:0] cmt_new, cmt_old, tag_srca, tag_srcb, tag_dst, tag_prev;
  logic flush, stall;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rename_unit dut_i (.clk(clk), .rst_n(rst_n), .ren_vld(ren_vld), .ren_wr(ren_wr),
    .ren_dst(ren_dst), .ren_srca(ren_srca), .ren_srcb(ren_srcb), .cmt_vld(cmt_vld),
    .cmt_arch(cmt_arch), .cmt_new(cmt_new), .cmt_old(cmt_old), .flush(flush),
    .tag_srca(tag_srca), .tag_srcb(tag_srcb), .tag_dst(tag_dst), .tag_prev(tag_prev),
    .stall(stall));

  function automatic logic [19:0] a4(int x3, int x2, int x1, int x0);
    return {5'(x3), 5'(x2), 5'(x1), 5'(x0)};
  endfunction
  function automatic logic [23:0] p4(int x3, int x2, int x1, int x0);
    return {6'(x3), 6'(x2), 6'(x1), 6'(x0)};
  endfunction

  typedef struct packed {
    logic [3:0] v, w;
    logic [19:0] d, a, b;
    logic [23:0] ed, ep, ea, eb;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{4'b1111, 4'b1111, a4(3,1,2,1), a4(1,2,1,1), a4(2,1,5,0),
      p4(35,34,33,32), p4(3,32,2,1), p4(34,33,32,1), p4(33,32,5,0)},
    '{4'b1011, 4'b1101, a4(1,1,9,4), a4(9,0,4,1), a4(1,0,2,3),
      p4(37,0,0,36), p4(34,0,0,4), p4(9,0,36,34), p4(34,0,33,35)},
    '{4'b0000, 4'b1111, a4(5,5,5,5), a4(3,2,4,1), a4(0,0,0,0),
      p4(0,0,0,0), p4(0,0,0,0), p4(35,33,36,37), p4(0,0,0,0)},
    '{4'b1111, 4'b1111, a4(13,12,11,10), a4(12,11,10,10), a4(0,0,0,0),
      p4(41,40,39,38), p4(13,12,11,10), p4(40,39,38,10), p4(0,0,0,0)}
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ren(input logic [3:0] v, input logic [3:0] w,
                     input logic [19:0] d, input logic [19:0] a, input logic [19:0] b);
    @(negedge clk);
    ren_vld = v; ren_wr = w; ren_dst = d; ren_srca = a; ren_srcb = b;
    cmt_vld = '0; cmt_arch = '0; cmt_new = '0; cmt_old = '0; flush = 1'b0;
    #1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    ren_vld = '0; ren_wr = '0; ren_dst = '0; ren_srca = '0; ren_srcb = '0;
    cmt_vld = '0; cmt_arch = '0; cmt_new = '0; cmt_old = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    ren(4'b0000, 4'b0000, '0, a4(7,6,5,4), '0);
    chk("R1 reset map", tag_srca, p4(7,6,5,4));
    chk("R1 reset stall", {23'd0, stall}, 24'd0);

    for (int k = 0; k < 4; k++) begin
      ren(TBL[k].v, TBL[k].w, TBL[k].d, TBL[k].a, TBL[k].b);
      chk("R2 R10 dst tags", tag_dst, TBL[k].ed);
      chk("R3 R4 prev tags", tag_prev, TBL[k].ep);
      chk("R4 srca tags", tag_srca, TBL[k].ea);
      chk("R4 R10 srcb tags", tag_srcb, TBL[k].eb);
      chk("R6 no stall", {23'd0, stall}, 24'd0);
    end

    for (int g = 0; g < 5; g++) begin
      ren(4'b1111, 4'b1111, a4(20,20,20,20), '0, '0);
      chk("R2 fill dst", tag_dst, p4(45+4*g, 44+4*g, 43+4*g, 42+4*g));
    end
    ren(4'b1111, 4'b1111, a4(20,20,20,20), '0, '0);
    chk("R6 short group stalls", {23'd0, stall}, 24'd1);
    ren(4'b0011, 4'b0011, a4(0,0,21,21), '0, '0);
    chk("R6 no partial alloc", tag_dst, p4(0,0,63,62));
    chk("R4 prev bypass", tag_prev, p4(0,0,62,21));
    chk("R6 pair accepted", {23'd0, stall}, 24'd0);
    ren(4'b0001, 4'b0001, a4(0,0,0,22), '0, '0);
    chk("R7 full window stalls", {23'd0, stall}, 24'd1);

    ren(4'b0000, 4'b0000, '0, '0, '0);
    cmt_vld = 4'b0001; cmt_arch = a4(0,0,0,1); cmt_new = p4(0,0,0,32); cmt_old = p4(0,0,0,1);
    ren(4'b0001, 4'b0001, a4(0,0,0,22), '0, '0);
    chk("R5 freed reg reused", tag_dst, p4(0,0,0,1));
    chk("R5 no stall", {23'd0, stall}, 24'd0);
    ren(4'b0001, 4'b0001, a4(0,0,0,23), '0, '0);
    chk("R7 stall again", {23'd0, stall}, 24'd1);

    ren(4'b1111, 4'b1111, a4(9,9,9,9), '0, '0);
    cmt_vld = 4'b0001; cmt_arch = a4(0,0,0,2); cmt_new = p4(0,0,0,33); cmt_old = p4(0,0,0,2);
    flush = 1'b1;
    #0.5;
    chk("R9 stall in flush", {23'd0, stall}, 24'd1);

    ren(4'b0011, 4'b0011, a4(0,0,8,7), a4(0,0,2,1), a4(0,0,22,20));
    chk("R8 alloc after flush", tag_dst, p4(0,0,33,1));
    chk("R9 srca restored", tag_srca, p4(0,0,2,32));
    chk("R8 srcb restored", tag_srcb, p4(0,0,22,20));
    chk("R8 prev restored", tag_prev, p4(0,0,8,7));

    for (int g = 0; g < 7; g++) begin
      ren(4'b1111, 4'b1111, a4(30,30,30,30), '0, '0);
      chk("R8 refill no stall", {23'd0, stall}, 24'd0);
    end
    ren(4'b0011, 4'b0011, a4(0,0,31,31), '0, '0);
    chk("R8 last pair", tag_dst, p4(0,0,63,62));
    ren(4'b0001, 4'b0001, a4(0,0,0,31), '0, '0);
    chk("R7 R8 count exhausted", {23'd0, stall}, 24'd1);

    ren(4'b0000, 4'b0000, '0, '0, '0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule